// File: doc/BRIEF.md
# Two-Region Bus Splitter with Debug Write Hooks

This block sits between a processor's single 32-bit request/acknowledge data bus and two downstream targets: a main memory port and an external peripheral port. Each transfer is steered by looking at the top two address bits. The lowest quarter of the address space goes to memory and everything else goes to the external port. Read data and the acknowledge come back from whichever port the current address selects.

A build-time switch adds two debug hooks on the external side. A write to one fixed address emits a one-cycle strobe that carries the low data byte. A write to a second fixed address raises a sticky halt request. Both hook writes still travel to the external port, and they take effect on that port's acknowledge. A testbench or wrapper can use the strobe and the halt request to print characters and to stop a run. With the switch off, both addresses are ordinary peripheral addresses.

Top module: `bus_splitter`

## Requirements
- R1: A transfer whose address has bits [31:30] equal to 2'b00 (0x00000000 to 0x3FFFFFFF) asserts `mem_stb` and leaves `ext_stb` low.
- R2: A transfer at any address from 0x40000000 to 0xFFFFFFFF asserts `ext_stb` and leaves `mem_stb` low. With `up_stb` low, neither strobe is asserted.
- R3: Address, write data, byte select and write enable are copied unchanged to both downstream ports.
- R4: `up_ack` follows the acknowledge of the selected port, and the other port's acknowledge has no effect. While `up_ack` is high, `up_rdat` equals the selected port's read data.
- R5: With `SIM_EN`=1, a write to 0x80000000 is forwarded to the external port. `log_valid` is high in exactly the cycles where that write is acknowledged by `ext_ack`, and `log_byte` then equals write data bits [7:0].
- R6: With `SIM_EN`=1, an acknowledged write to 0x90000000 raises `halt_req` in the acknowledge cycle. `halt_req` stays high until a synchronous `rst`.
- R7: Reads from 0x80000000 or 0x90000000 produce neither a `log_valid` pulse nor `halt_req`.
- R8: With `SIM_EN`=0, `log_valid` and `halt_req` stay low for every access, including writes to the two hook addresses.
- R9: After reset, `halt_req` and `log_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_adr | input | 32 | Upstream address |
| up_wdat | input | 32 | Upstream write data |
| up_sel | input | 4 | Upstream byte select |
| up_we | input | 1 | Upstream write enable |
| up_stb | input | 1 | Upstream transfer strobe |
| up_rdat | output | 32 | Read data back to the master |
| up_ack | output | 1 | Acknowledge back to the master |
| mem_adr | output | 32 | Memory port address |
| mem_wdat | output | 32 | Memory port write data |
| mem_sel | output | 4 | Memory port byte select |
| mem_we | output | 1 | Memory port write enable |
| mem_stb | output | 1 | Memory port strobe |
| mem_rdat | input | 32 | Memory port read data |
| mem_ack | input | 1 | Memory port acknowledge |
| ext_adr | output | 32 | External port address |
| ext_wdat | output | 32 | External port write data |
| ext_sel | output | 4 | External port byte select |
| ext_we | output | 1 | External port write enable |
| ext_stb | output | 1 | External port strobe |
| ext_rdat | input | 32 | External port read data |
| ext_ack | input | 1 | External port acknowledge |
| log_valid | output | 1 | One-cycle strobe for a debug log byte |
| log_byte | output | 8 | Debug log byte |
| halt_req | output | 1 | Sticky end-of-run request |

## Verification
The bench builds two copies of the block with the default 32-bit widths: one with `SIM_EN`=1 and one with `SIM_EN`=0. Both copies are driven from the same stimulus. The sweep walks every 6-bit value of the top address bits and adds both region boundaries (0x3FFFFFFC and 0x40000000), so every decode outcome is covered. For each address it tries all four acknowledge combinations with both reads and writes. The two copies side by side make it possible to check the hook addresses with the switch on and off under the same traffic, including that `halt_req` stays set until reset.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

   typedef enum logic {
      PORT_MEM = 1'b0,
      PORT_EXT = 1'b1
   } port_sel_e;

   localparam int unsigned LOG_BYTE_W = 8;

endpackage

// File: rtl/bsplit_decode.sv
module bsplit_decode
   import bsplit_pkg::*;
#(
   parameter int unsigned TAG_W   = 2,
   parameter logic [TAG_W-1:0] MEM_TAG = '0
) (
   input  logic [TAG_W-1:0] adr_tag,
   output port_sel_e        sel
);

   always_comb begin
      if (adr_tag == MEM_TAG) sel = PORT_MEM;
      else                    sel = PORT_EXT;
   end

endmodule

// File: rtl/bsplit_return.sv
module bsplit_return
   import bsplit_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  port_sel_e         sel,
   input  logic              req_stb,
   input  logic [DATA_W-1:0] mem_rdat,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] ext_rdat,
   input  logic              ext_ack,
   output logic [DATA_W-1:0] rdat,
   output logic              ack
);

   always_comb begin
      unique case (sel)
         PORT_MEM: begin
            rdat = mem_rdat;
            ack  = req_stb & mem_ack;
         end
         default: begin
            rdat = ext_rdat;
            ack  = req_stb & ext_ack;
         end
      endcase
   end

endmodule

// File: rtl/bsplit_simhook.sv
module bsplit_simhook
   import bsplit_pkg::*;
#(
   parameter int unsigned  ADDR_W    = 32,
   parameter bit           SIM_EN    = 1'b0,
   parameter logic [ADDR_W-1:0] LOG_ADDR  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h9000_0000
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  req_stb,
   input  logic                  req_we,
   input  logic [ADDR_W-1:0]     req_adr,
   input  logic [LOG_BYTE_W-1:0] req_lo,
   input  logic                  ext_done,
   output logic                  log_valid,
   output logic [LOG_BYTE_W-1:0] log_byte,
   output logic                  halt_req
);

   generate
      if (SIM_EN) begin : g_hooks
         logic wr_done;
         logic log_hit;
         logic halt_hit;
         logic halt_q;

         assign wr_done  = req_stb & req_we & ext_done;
         assign log_hit  = wr_done & (req_adr == LOG_ADDR);
         assign halt_hit = wr_done & (req_adr == HALT_ADDR);

         always_ff @(posedge clk) begin
            if (rst)           halt_q <= 1'b0;
            else if (halt_hit) halt_q <= 1'b1;
         end

         assign log_valid = log_hit;
         assign log_byte  = log_hit ? req_lo : '0;
         assign halt_req  = halt_q | halt_hit;
      end else begin : g_no_hooks
         logic unused_hook_in;
         assign unused_hook_in = ^{clk, rst, req_stb, req_we, req_adr, req_lo, ext_done};
         assign log_valid = 1'b0;
         assign log_byte  = '0;
         assign halt_req  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bus_splitter.sv
module bus_splitter
   import bsplit_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TAG_W     = 2,
   parameter bit          SIM_EN    = 1'b0,
   parameter logic [ADDR_W-1:0] LOG_ADDR  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h9000_0000,
   localparam int unsigned SEL_W    = DATA_W / 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     up_adr,
   input  logic [DATA_W-1:0]     up_wdat,
   input  logic [SEL_W-1:0]      up_sel,
   input  logic                  up_we,
   input  logic                  up_stb,
   output logic [DATA_W-1:0]     up_rdat,
   output logic                  up_ack,
   output logic [ADDR_W-1:0]     mem_adr,
   output logic [DATA_W-1:0]     mem_wdat,
   output logic [SEL_W-1:0]      mem_sel,
   output logic                  mem_we,
   output logic                  mem_stb,
   input  logic [DATA_W-1:0]     mem_rdat,
   input  logic                  mem_ack,
   output logic [ADDR_W-1:0]     ext_adr,
   output logic [DATA_W-1:0]     ext_wdat,
   output logic [SEL_W-1:0]      ext_sel,
   output logic                  ext_we,
   output logic                  ext_stb,
   input  logic [DATA_W-1:0]     ext_rdat,
   input  logic                  ext_ack,
   output logic                  log_valid,
   output logic [LOG_BYTE_W-1:0] log_byte,
   output logic                  halt_req
);

   localparam int unsigned TAG_LSB = ADDR_W - TAG_W;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_dw
         $error("bus_splitter: DATA_W must be a multiple of 8");
      end
      if (TAG_W < 1 || TAG_W >= ADDR_W) begin : g_bad_tag
         $error("bus_splitter: TAG_W out of range");
      end
      if (SIM_EN && (LOG_ADDR[ADDR_W-1 -: TAG_W] == '0 ||
                     HALT_ADDR[ADDR_W-1 -: TAG_W] == '0)) begin : g_bad_hook
         $error("bus_splitter: hook addresses must lie in the external region");
      end
      if (SIM_EN && LOG_ADDR == HALT_ADDR) begin : g_same_hook
         $error("bus_splitter: hook addresses must differ");
      end
   endgenerate

   port_sel_e port_sel;

   bsplit_decode #(
      .TAG_W   (TAG_W),
      .MEM_TAG ('0)
   ) u_decode (
      .adr_tag (up_adr[ADDR_W-1:TAG_LSB]),
      .sel     (port_sel)
   );

   // request fields are broadcast; only the strobe is steered
   assign mem_adr  = up_adr;
   assign mem_wdat = up_wdat;
   assign mem_sel  = up_sel;
   assign mem_we   = up_we;
   assign ext_adr  = up_adr;
   assign ext_wdat = up_wdat;
   assign ext_sel  = up_sel;
   assign ext_we   = up_we;

   assign mem_stb  = up_stb & (port_sel == PORT_MEM);
   assign ext_stb  = up_stb & (port_sel == PORT_EXT);

   bsplit_return #(
      .DATA_W (DATA_W)
   ) u_return (
      .sel      (port_sel),
      .req_stb  (up_stb),
      .mem_rdat (mem_rdat),
      .mem_ack  (mem_ack),
      .ext_rdat (ext_rdat),
      .ext_ack  (ext_ack),
      .rdat     (up_rdat),
      .ack      (up_ack)
   );

   bsplit_simhook #(
      .ADDR_W    (ADDR_W),
      .SIM_EN    (SIM_EN),
      .LOG_ADDR  (LOG_ADDR),
      .HALT_ADDR (HALT_ADDR)
   ) u_hook (
      .clk       (clk),
      .rst       (rst),
      .req_stb   (ext_stb),
      .req_we    (up_we),
      .req_adr   (up_adr),
      .req_lo    (up_wdat[LOG_BYTE_W-1:0]),
      .ext_done  (ext_ack),
      .log_valid (log_valid),
      .log_byte  (log_byte),
      .halt_req  (halt_req)
   );

endmodule

// File: rtl/bus_splitter_chk.sv
module bus_splitter_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter bit          SIM_EN = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] up_adr,
   input logic              up_we,
   input logic              up_stb,
   input logic              up_ack,
   input logic              mem_stb,
   input logic              mem_ack,
   input logic              ext_stb,
   input logic              ext_ack,
   input logic              log_valid,
   input logic              halt_req
);

   // R1
   mem_region_chk: assert property (@(posedge clk) disable iff (rst)
      mem_stb |-> (up_adr[ADDR_W-1 -: 2] == 2'b00 && !ext_stb));

   // R2
   one_port_chk: assert property (@(posedge clk) disable iff (rst)
      up_stb == (mem_stb || ext_stb) && $onehot0({mem_stb, ext_stb}));

   // R4
   ack_source_chk: assert property (@(posedge clk) disable iff (rst)
      up_ack |-> ((mem_stb && mem_ack) || (ext_stb && ext_ack)));

   // R6
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halt_req |=> halt_req);

   generate
      if (SIM_EN) begin : g_on
         // R5
         log_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
            log_valid |-> (up_we && ext_stb && ext_ack));
      end else begin : g_off
         // R8
         hooks_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !log_valid && !halt_req);
      end
   endgenerate

endmodule

bind bus_splitter bus_splitter_chk #(
   .ADDR_W (ADDR_W),
   .SIM_EN (SIM_EN)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .up_adr    (up_adr),
   .up_we     (up_we),
   .up_stb    (up_stb),
   .up_ack    (up_ack),
   .mem_stb   (mem_stb),
   .mem_ack   (mem_ack),
   .ext_stb   (ext_stb),
   .ext_ack   (ext_ack),
   .log_valid (log_valid),
   .halt_req  (halt_req)
);

// File: tb/bus_splitter_test.sv
`timescale 1ns/1ps
module bus_splitter_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] up_adr = '0, up_wdat = '0;
   logic [3:0]  up_sel = '0;
   logic        up_we = 1'b0, up_stb = 1'b0;
   logic        mack = 1'b0, xack = 1'b0;
   logic [31:0] mem_rdat, ext_rdat;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // downstream models: read data derived from the address
   assign mem_rdat = ~up_adr;
   assign ext_rdat = up_adr ^ 32'hA5C3_3C5A;

   logic [31:0] a_rdat, a_madr, a_mwd, a_xadr, a_xwd, b_rdat;
   logic [31:0] b_madr, b_mwd, b_xadr, b_xwd;
   logic [3:0]  a_msel, a_xsel, b_msel, b_xsel;
   logic        a_ack, a_mwe, a_mstb, a_xwe, a_xstb, a_log, a_halt;
   logic        b_ack, b_mwe, b_mstb, b_xwe, b_xstb, b_log, b_halt;
   logic [7:0]  a_lb, b_lb;

   bus_splitter #(.SIM_EN(1'b1)) uut (
      .clk(clk), .rst(rst), .up_adr(up_adr), .up_wdat(up_wdat), .up_sel(up_sel),
      .up_we(up_we), .up_stb(up_stb), .up_rdat(a_rdat), .up_ack(a_ack),
      .mem_adr(a_madr), .mem_wdat(a_mwd), .mem_sel(a_msel), .mem_we(a_mwe),
      .mem_stb(a_mstb), .mem_rdat(mem_rdat), .mem_ack(mack),
      .ext_adr(a_xadr), .ext_wdat(a_xwd), .ext_sel(a_xsel), .ext_we(a_xwe),
      .ext_stb(a_xstb), .ext_rdat(ext_rdat), .ext_ack(xack),
      .log_valid(a_log), .log_byte(a_lb), .halt_req(a_halt));

   bus_splitter #(.SIM_EN(1'b0)) uut_nosim (
      .clk(clk), .rst(rst), .up_adr(up_adr), .up_wdat(up_wdat), .up_sel(up_sel),
      .up_we(up_we), .up_stb(up_stb), .up_rdat(b_rdat), .up_ack(b_ack),
      .mem_adr(b_madr), .mem_wdat(b_mwd), .mem_sel(b_msel), .mem_we(b_mwe),
      .mem_stb(b_mstb), .mem_rdat(mem_rdat), .mem_ack(mack),
      .ext_adr(b_xadr), .ext_wdat(b_xwd), .ext_sel(b_xsel), .ext_we(b_xwe),
      .ext_stb(b_xstb), .ext_rdat(ext_rdat), .ext_ack(xack),
      .log_valid(b_log), .log_byte(b_lb), .halt_req(b_halt));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sweep_one(input logic [31:0] adr);
      for (int we = 0; we < 2; we++) begin
         for (int ak = 0; ak < 4; ak++) begin
            bit          in_mem;
            logic [31:0] exp_rd;
            logic        exp_ack;
            up_adr  = adr;
            up_we   = we[0];
            up_stb  = 1'b1;
            up_wdat = adr ^ 32'h1357_9BDF;
            up_sel  = adr[5:2];
            mack    = ak[0];
            xack    = ak[1];
            #0.5;
            in_mem  = (adr[31:30] == 2'b00);
            exp_ack = in_mem ? ak[0] : ak[1];
            exp_rd  = in_mem ? ~adr : (adr ^ 32'hA5C3_3C5A);
            // R1 R2
            chk({a_mstb, a_xstb} == {in_mem, !in_mem} &&
                {b_mstb, b_xstb} == {in_mem, !in_mem},
                "R1/R2 strobe", {62'd0, a_mstb, a_xstb}, {62'd0, in_mem, !in_mem});
            // R3
            chk(a_madr == adr && a_xadr == adr && a_mwd == up_wdat && a_xwd == up_wdat &&
                a_msel == up_sel && a_xsel == up_sel && a_mwe == we[0] && a_xwe == we[0],
                "R3 broadcast", {a_madr, a_xwd}, {adr, up_wdat});
            // R4
            chk(a_ack == exp_ack && b_ack == exp_ack && (!exp_ack || (a_rdat == exp_rd)),
                "R4 return", {31'd0, a_ack, a_rdat}, {31'd0, exp_ack, exp_rd});
            // R7 R8: no hook activity on ordinary traffic
            chk(!a_log && !b_log && !a_halt && !b_halt, "R8 quiet",
                {60'd0, a_log, b_log, a_halt, b_halt}, 64'd0);
            #0.5;
         end
      end
   endtask

   task automatic idle();
      up_stb = 1'b0; up_we = 1'b0; mack = 1'b0; xack = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      chk(!a_halt && !a_log && !b_halt && !b_log, "R9 reset",
          {62'd0, a_halt, a_log}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(!a_halt && !a_log, "R9 after reset", {62'd0, a_halt, a_log}, 64'd0);

      // boundaries and sweep of the top six address bits
      sweep_one(32'h3FFF_FFFC);
      sweep_one(32'h4000_0000);
      sweep_one(32'h0000_0000);
      sweep_one(32'hFFFF_FFFC);
      for (int i = 0; i < 64; i++) sweep_one((32'(i) << 26) | (32'(i) << 2));
      // no stb: nothing selected, no ack (R2, R4)
      idle(); mack = 1'b1; xack = 1'b1; up_adr = 32'h8000_0000; #0.5;
      chk(!a_mstb && !a_xstb && !a_ack, "R2 idle", {61'd0, a_mstb, a_xstb, a_ack}, 64'd0);
      idle();

      // R5 log write, ack withheld then given
      @(negedge clk);
      up_adr = 32'h8000_0000; up_we = 1'b1; up_stb = 1'b1; up_wdat = 32'hDEAD_BE5A;
      #0.5;
      chk(!a_log && a_xstb, "R5 before ack", {62'd0, a_log, a_xstb}, 64'd1);
      xack = 1'b1; #0.5;
      chk(a_log && a_lb == 8'h5A && a_ack, "R5 log pulse", {55'd0, a_log, a_lb}, {55'd1, 8'h5A});
      chk(!b_log && !b_halt, "R8 log off", {62'd0, b_log, b_halt}, 64'd0);
      @(negedge clk); idle(); #0.5;
      chk(!a_log, "R5 single cycle", {63'd0, a_log}, 64'd0);

      // R7 reads of hook addresses
      @(negedge clk);
      up_adr = 32'h8000_0000; up_stb = 1'b1; xack = 1'b1; #0.5;
      chk(!a_log && !a_halt, "R7 read log addr", {62'd0, a_log, a_halt}, 64'd0);
      @(negedge clk); up_adr = 32'h9000_0000; #0.5;
      chk(!a_log && !a_halt, "R7 read halt addr", {62'd0, a_log, a_halt}, 64'd0);
      @(negedge clk); idle(); @(negedge clk);
      chk(!a_halt, "R7 no halt latched", {63'd0, a_halt}, 64'd0);

      // R6 halt write
      up_adr = 32'h9000_0000; up_we = 1'b1; up_stb = 1'b1; up_wdat = 32'h1; #0.5;
      chk(!a_halt, "R6 before ack", {63'd0, a_halt}, 64'd0);
      xack = 1'b1; #0.5;
      chk(a_halt && !a_log, "R6 on ack", {62'd0, a_halt, a_log}, 64'd2);
      @(negedge clk); idle();
      repeat (4) @(negedge clk);
      chk(a_halt, "R6 sticky", {63'd0, a_halt}, 64'd1);
      chk(!b_halt && !b_log, "R8 halt off", {62'd0, b_halt, b_log}, 64'd0);
      rst = 1'b1; @(negedge clk); rst = 1'b0; #0.5;
      chk(!a_halt, "R6 cleared by reset", {63'd0, a_halt}, 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule